// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block buffers 36-bit words between two unrelated clock domains. A producer on port A writes words on its own clock; a consumer on port B sees the oldest word already waiting in an output register, with a valid flag, so it needs no read request to fetch it first. Each port accepts an access only when the access decode is a FIFO access: chip-select asserted (low), direction select high, mailbox select low and enable high. Any other combination leaves the FIFO untouched.

Port A gets an input-ready flag and an active-low almost-full flag. Port B gets an output-ready flag and an active-low almost-empty flag. Each flag is computed in the clock domain of the port that uses it. Binary pointers with one extra wrap bit are converted to Gray code and pass through two-flop synchronizers before the other domain compares them. Both thresholds come from a one-cycle load strobe on the write clock. Writes stay blocked after reset until that strobe has been seen.

Top module: `dual_clk_fwft_fifo`

## Requirements
- R1: A write happens on a rising `a_clk` only when `a_cs_n`=0, `a_wr`=1, `a_mb`=0, `a_en`=1 and `a_ready`=1. Any other decode stores nothing.
- R2: Write attempts made while `a_ready` is low are dropped: no word reaches port B because of them.
- R3: After reset, `a_ready` stays low until `cfg_load` is sampled high on `a_clk`. From that edge on it is high while the FIFO is not full.
- R4: After reset, `b_ready` and `b_almost_empty_n` are low and `a_almost_full_n` is high.
- R5: When a word is written into an empty FIFO with an empty output register, it appears on `b_data` with `b_ready` high after the 3rd `b_clk` rising edge following the write edge, or the 4th when the clocks are close in phase.
- R6: A read pops the output word on a rising `b_clk` only when `b_cs_n`=0, `b_wr`=1, `b_mb`=0, `b_en`=1 and `b_ready`=1. Otherwise `b_data` and `b_ready` hold. After the last word is popped, `b_ready` falls.
- R7: Words leave port B in the order they were written, with every bit unchanged.
- R8: Total capacity is DEPTH+1 words: DEPTH in storage plus the output register. Once it is reached, `a_ready` is low.
- R9: When a read frees space in a full FIFO, `a_ready` rises after the 3rd `a_clk` rising edge following the read edge, or the 4th.
- R10: `b_almost_empty_n` is low while the words held (storage plus output register) are at most the loaded almost-empty offset, and high when they exceed it.
- R11: `a_almost_full_n` is low while the free storage words (DEPTH minus words in storage, output register excluded) are at most the loaded almost-full offset, and high otherwise.
- R12: Asserting `rst_n` mid-operation discards all stored words and the output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain through synchronizers |
| a_cs_n | input | 1 | Port A chip-select, active low |
| a_wr | input | 1 | Port A direction select, 1 = FIFO write |
| a_mb | input | 1 | Port A mailbox select, must be 0 for FIFO access |
| a_en | input | 1 | Port A enable |
| a_data | input | WORD_W | Write data |
| cfg_load | input | 1 | Strobe capturing both offsets on `a_clk` |
| cfg_ae_ofs | input | log2(DEPTH) | Almost-empty offset |
| cfg_af_ofs | input | log2(DEPTH) | Almost-full offset |
| a_ready | output | 1 | Input-ready: a qualified write will be taken |
| a_almost_full_n | output | 1 | Low when free storage is at or below the almost-full offset |
| b_clk | input | 1 | Read-side clock |
| b_cs_n | input | 1 | Port B chip-select, active low |
| b_wr | input | 1 | Port B direction select, 1 = FIFO read |
| b_mb | input | 1 | Port B mailbox select, must be 0 for FIFO access |
| b_en | input | 1 | Port B enable |
| b_data | output | WORD_W | Output register holding the oldest word |
| b_ready | output | 1 | Output-ready: `b_data` is valid |
| b_almost_empty_n | output | 1 | Low when words held are at or below the almost-empty offset |

## Verification
A corrupt write or read pointer shows up at port B as a missing, repeated or out-of-order word on the next pop. It also shows as a capacity other than DEPTH+1 the first time the FIFO fills. A synchronizer or flag register that is stuck or off by a stage shows up as an output-ready or input-ready latency outside the 3-to-4 edge window, which is measured edge by edge after a single write into an empty FIFO and after a single read from a full one. A wrong occupancy count shows up at the threshold boundaries, where adding or removing one word must flip the almost flags within a few clocks of settling.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    localparam int CODE_W = 16;
    typedef logic [CODE_W-1:0] code_t;

    function automatic code_t bin_to_gray(input code_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic code_t gray_to_bin(input code_t g);
        code_t b;
        b[CODE_W-1] = g[CODE_W-1];
        for (int i = CODE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // One decode for both ports: select low, direction high, mailbox low, enable high
    function automatic logic fifo_access(input logic cs_n, input logic dir,
                                         input logic mbox, input logic en);
        return !cs_n && dir && !mbox && en;
    endfunction

endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = d;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign q = sy_q.s2;

endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
    parameter int WORD_W = 36,
    parameter int DEPTH  = 512,
    parameter int ADDR_W = 9
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] store_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    // The read side only addresses entries whose write is at least two syncs old
    assign rdata = store_q[raddr];

endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl
    import fifo_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = 9,
    parameter int PTR_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_cs_n,
    input  logic              a_wr,
    input  logic              a_mb,
    input  logic              a_en,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] ae_ofs_in,
    input  logic [ADDR_W-1:0] af_ofs_in,
    input  logic [PTR_W-1:0]  rgray_sync,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [PTR_W-1:0]  wptr_bin,
    output logic [PTR_W-1:0]  wgray,
    output logic [PTR_W-1:0]  rptr_seen,
    output logic              ready,
    output logic              almost_full_n,
    output logic              cfg_done,
    output logic [ADDR_W-1:0] ae_ofs
);

    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [PTR_W-1:0]  gray;
        logic              cfg;
        logic              ir;
        logic              af_n;
        logic [ADDR_W-1:0] ae_ofs;
        logic [ADDR_W-1:0] af_ofs;
    } wst_t;

    localparam wst_t WST_RESET = '{
        ptr:    '0,
        gray:   '0,
        cfg:    1'b0,
        ir:     1'b0,
        af_n:   1'b1,
        ae_ofs: '0,
        af_ofs: '0
    };

    wst_t             st_d, st_q;
    logic             push;
    logic [PTR_W-1:0] rbin;
    logic [PTR_W-1:0] used_d;
    logic [PTR_W-1:0] free_d;

    always_comb begin
        st_d = st_q;
        push = fifo_access(a_cs_n, a_wr, a_mb, a_en) && st_q.ir;
        rbin = PTR_W'(gray_to_bin(CODE_W'(rgray_sync)));

        if (cfg_load) begin
            st_d.cfg    = 1'b1;
            st_d.ae_ofs = ae_ofs_in;
            st_d.af_ofs = af_ofs_in;
        end

        if (push) begin
            st_d.ptr = st_q.ptr + PTR_W'(1);
        end
        st_d.gray = PTR_W'(bin_to_gray(CODE_W'(st_d.ptr)));

        // Flags look at the post-write pointer so a write that fills drops ready at once
        used_d    = st_d.ptr - rbin;
        free_d    = DEPTH_P - used_d;
        st_d.ir   = st_d.cfg && (used_d != DEPTH_P);
        st_d.af_n = free_d > PTR_W'(st_d.af_ofs);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= WST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we        = push;
    assign mem_waddr     = st_q.ptr[ADDR_W-1:0];
    assign wptr_bin      = st_q.ptr;
    assign wgray         = st_q.gray;
    assign rptr_seen     = rbin;
    assign ready         = st_q.ir;
    assign almost_full_n = st_q.af_n;
    assign cfg_done      = st_q.cfg;
    assign ae_ofs        = st_q.ae_ofs;

endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl
    import fifo_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 9,
    parameter int PTR_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              b_cs_n,
    input  logic              b_wr,
    input  logic              b_mb,
    input  logic              b_en,
    input  logic [PTR_W-1:0]  wgray_sync,
    input  logic [ADDR_W-1:0] ae_ofs,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [PTR_W-1:0]  rgray,
    output logic [WORD_W-1:0] out_data,
    output logic              out_ready,
    output logic              almost_empty_n
);

    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [PTR_W-1:0]  gray;
        logic              ready;
        logic              ae_n;
        logic [WORD_W-1:0] data;
    } rst_t;

    rst_t             st_d, st_q;
    logic             pop;
    logic             avail;
    logic             load;
    logic [PTR_W-1:0] wbin;
    logic [CNT_W-1:0] held_d;

    always_comb begin
        st_d  = st_q;
        pop   = fifo_access(b_cs_n, b_wr, b_mb, b_en) && st_q.ready;
        wbin  = PTR_W'(gray_to_bin(CODE_W'(wgray_sync)));
        avail = wbin != st_q.ptr;
        // Refill the output register whenever it is empty or being emptied
        load  = (!st_q.ready || pop) && avail;

        if (load) begin
            st_d.data  = mem_rdata;
            st_d.ptr   = st_q.ptr + PTR_W'(1);
            st_d.ready = 1'b1;
        end else if (pop) begin
            st_d.ready = 1'b0;
        end
        st_d.gray = PTR_W'(bin_to_gray(CODE_W'(st_d.ptr)));

        held_d    = {1'b0, wbin - st_d.ptr} + CNT_W'(st_d.ready);
        st_d.ae_n = held_d > CNT_W'(ae_ofs);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_raddr      = st_q.ptr[ADDR_W-1:0];
    assign rgray          = st_q.gray;
    assign out_data       = st_q.data;
    assign out_ready      = st_q.ready;
    assign almost_empty_n = st_q.ae_n;

endmodule

// File: rtl/dual_clk_fwft_fifo.sv
module dual_clk_fwft_fifo #(
    parameter int  WORD_W = 36,
    parameter int  DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              a_clk,
    input  logic              rst_n,
    input  logic              a_cs_n,
    input  logic              a_wr,
    input  logic              a_mb,
    input  logic              a_en,
    input  logic [WORD_W-1:0] a_data,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_ae_ofs,
    input  logic [ADDR_W-1:0] cfg_af_ofs,
    output logic              a_ready,
    output logic              a_almost_full_n,
    input  logic              b_clk,
    input  logic              b_cs_n,
    input  logic              b_wr,
    input  logic              b_mb,
    input  logic              b_en,
    output logic [WORD_W-1:0] b_data,
    output logic              b_ready,
    output logic              b_almost_empty_n
);

    localparam int PTR_W = ADDR_W + 1;

    logic              wrst_n;
    logic              rrst_n;
    logic [PTR_W-1:0]  wgray;
    logic [PTR_W-1:0]  rgray;
    logic [PTR_W-1:0]  wgray_s;
    logic [PTR_W-1:0]  rgray_s;
    logic [PTR_W-1:0]  wptr_bin;
    logic [PTR_W-1:0]  rptr_seen;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [WORD_W-1:0] mem_rdata;
    logic              cfg_done;
    logic [ADDR_W-1:0] ae_ofs;

    fifo_sync #(.W(1)) u_wrst_sync (
        .clk(a_clk), .rst_n(rst_n), .d(1'b1), .q(wrst_n)
    );

    fifo_sync #(.W(1)) u_rrst_sync (
        .clk(b_clk), .rst_n(rst_n), .d(1'b1), .q(rrst_n)
    );

    fifo_sync #(.W(PTR_W)) u_rptr_to_w (
        .clk(a_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
    );

    fifo_sync #(.W(PTR_W)) u_wptr_to_r (
        .clk(b_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
    );

    fifo_wr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_wr (
        .clk           (a_clk),
        .rst_n         (wrst_n),
        .a_cs_n        (a_cs_n),
        .a_wr          (a_wr),
        .a_mb          (a_mb),
        .a_en          (a_en),
        .cfg_load      (cfg_load),
        .ae_ofs_in     (cfg_ae_ofs),
        .af_ofs_in     (cfg_af_ofs),
        .rgray_sync    (rgray_s),
        .mem_we        (mem_we),
        .mem_waddr     (mem_waddr),
        .wptr_bin      (wptr_bin),
        .wgray         (wgray),
        .rptr_seen     (rptr_seen),
        .ready         (a_ready),
        .almost_full_n (a_almost_full_n),
        .cfg_done      (cfg_done),
        .ae_ofs        (ae_ofs)
    );

    fifo_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .wclk  (a_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (a_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    fifo_rd_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_rd (
        .clk            (b_clk),
        .rst_n          (rrst_n),
        .b_cs_n         (b_cs_n),
        .b_wr           (b_wr),
        .b_mb           (b_mb),
        .b_en           (b_en),
        .wgray_sync     (wgray_s),
        .ae_ofs         (ae_ofs),
        .mem_rdata      (mem_rdata),
        .mem_raddr      (mem_raddr),
        .rgray          (rgray),
        .out_data       (b_data),
        .out_ready      (b_ready),
        .almost_empty_n (b_almost_empty_n)
    );

endmodule

// File: rtl/fifo_chk.sv
module fifo_chk
    import fifo_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int DEPTH  = 512,
    parameter int PTR_W  = 10
) (
    input logic              wclk,
    input logic              rclk,
    input logic              wrst_n,
    input logic              rrst_n,
    input logic              a_ready,
    input logic              cfg_done,
    input logic [PTR_W-1:0]  wptr_bin,
    input logic [PTR_W-1:0]  rptr_seen,
    input logic              b_cs_n,
    input logic              b_wr,
    input logic              b_mb,
    input logic              b_en,
    input logic              b_ready,
    input logic [WORD_W-1:0] b_data,
    input logic              b_almost_empty_n
);

    logic rd_fire;
    assign rd_fire = fifo_access(b_cs_n, b_wr, b_mb, b_en) && b_ready;

    p_ignore_not_ready_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
        !a_ready |=> $stable(wptr_bin));

    p_no_overflow_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wptr_bin - rptr_seen) <= PTR_W'(DEPTH));

    p_cfg_gate_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
        !cfg_done |-> !a_ready);

    p_hold_output_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
        (b_ready && !rd_fire) |=> (b_ready && $stable(b_data)));

    p_idle_almost_empty_r10: assert property (@(posedge rclk) disable iff (!rrst_n)
        !b_ready |-> !b_almost_empty_n);

endmodule

bind dual_clk_fwft_fifo fifo_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_fifo_chk (
    .wclk             (a_clk),
    .rclk             (b_clk),
    .wrst_n           (wrst_n),
    .rrst_n           (rrst_n),
    .a_ready          (a_ready),
    .cfg_done         (cfg_done),
    .wptr_bin         (wptr_bin),
    .rptr_seen        (rptr_seen),
    .b_cs_n           (b_cs_n),
    .b_wr             (b_wr),
    .b_mb             (b_mb),
    .b_en             (b_en),
    .b_ready          (b_ready),
    .b_data           (b_data),
    .b_almost_empty_n (b_almost_empty_n)
);

// File: tb/tb_dual_clk_fwft_fifo.sv
`timescale 1ns/100ps
module tb_dual_clk_fwft_fifo;

    localparam realtime WCLK_PERIOD = 10.0;
    localparam realtime RCLK_PERIOD = 13.0;
    localparam int WORD_W = 36;
    localparam int DEPTH  = 512;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int AE_X   = 4;
    localparam int AF_Y   = 8;

    typedef struct packed {
        logic [7:0]        n_wr;
        logic [7:0]        n_rd;
        logic [WORD_W-1:0] seed;
        logic              exp_ready;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'd3,  8'd3,  36'h0_1234_5678, 1'b0},
        '{8'd5,  8'd2,  36'hF_0000_0001, 1'b1},
        '{8'd1,  8'd4,  36'hA_AAAA_AAAA, 1'b0},
        '{8'd20, 8'd10, 36'h5_5555_5555, 1'b1},
        '{8'd0,  8'd10, 36'h0_0000_0000, 1'b0},
        '{8'd16, 8'd16, 36'hC_0FFE_E000, 1'b0},
        '{8'd2,  8'd1,  36'h8_0000_0000, 1'b1},
        '{8'd0,  8'd1,  36'h0_0000_0000, 1'b0}
    };

    logic              a_clk = 1'b0;
    logic              b_clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              a_cs_n = 1'b1, a_wr = 1'b0, a_mb = 1'b0, a_en = 1'b0;
    logic [WORD_W-1:0] a_data = '0;
    logic              cfg_load = 1'b0;
    logic [ADDR_W-1:0] cfg_ae_ofs = '0, cfg_af_ofs = '0;
    logic              b_cs_n = 1'b1, b_wr = 1'b0, b_mb = 1'b0, b_en = 1'b0;
    logic              a_ready, a_almost_full_n;
    logic [WORD_W-1:0] b_data;
    logic              b_ready, b_almost_empty_n;

    int n_chk  = 0;
    int n_fail = 0;
    logic [WORD_W-1:0] exp_q [$];

    dual_clk_fwft_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) dut (
        .a_clk(a_clk), .rst_n(rst_n), .a_cs_n(a_cs_n), .a_wr(a_wr), .a_mb(a_mb),
        .a_en(a_en), .a_data(a_data), .cfg_load(cfg_load), .cfg_ae_ofs(cfg_ae_ofs),
        .cfg_af_ofs(cfg_af_ofs), .a_ready(a_ready), .a_almost_full_n(a_almost_full_n),
        .b_clk(b_clk), .b_cs_n(b_cs_n), .b_wr(b_wr), .b_mb(b_mb), .b_en(b_en),
        .b_data(b_data), .b_ready(b_ready), .b_almost_empty_n(b_almost_empty_n)
    );

    always #(WCLK_PERIOD / 2.0) a_clk = ~a_clk;
    initial begin
        #1.3;
        forever #(RCLK_PERIOD / 2.0) b_clk = ~b_clk;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_lat(input string req, input int n, input int lo, input int hi);
        n_chk++;
        if (n < lo || n > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d edges expected=%0d..%0d edges", req, n, lo, hi);
        end
    endtask

    task automatic wait_w(input int n);
        repeat (n) @(negedge a_clk);
    endtask

    task automatic wait_r(input int n);
        repeat (n) @(negedge b_clk);
    endtask

    task automatic push_word(input logic [WORD_W-1:0] d);
        @(negedge a_clk);
        while (!a_ready) @(negedge a_clk);
        a_cs_n = 1'b0; a_wr = 1'b1; a_mb = 1'b0; a_en = 1'b1; a_data = d;
        @(posedge a_clk);
        a_en <= 1'b0; a_cs_n <= 1'b1;
        exp_q.push_back(d);
    endtask

    task automatic pop_word(input string req);
        @(negedge b_clk);
        while (!b_ready) @(negedge b_clk);
        if (exp_q.size() == 0) check(req, 64'(b_data), 64'h0);
        else check(req, 64'(b_data), 64'(exp_q.pop_front()));
        b_cs_n = 1'b0; b_wr = 1'b1; b_mb = 1'b0; b_en = 1'b1;
        @(posedge b_clk);
        b_en <= 1'b0; b_cs_n <= 1'b1;
    endtask

    task automatic drain(input string req);
        while (exp_q.size() > 0) pop_word(req);
        wait_r(10);
    endtask

    task automatic load_cfg();
        @(negedge a_clk);
        cfg_load = 1'b1; cfg_ae_ofs = ADDR_W'(AE_X); cfg_af_ofs = ADDR_W'(AF_Y);
        @(posedge a_clk);
        cfg_load <= 1'b0;
    endtask

    initial begin
        #(WCLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [WORD_W-1:0] w1, w2;
        int n, accepted, idle;

        wait_w(5);
        rst_n = 1'b1;
        wait_w(5);
        // R4 / R3: reset state before offsets are loaded
        check("R4 b_ready after reset", 64'(b_ready), 64'h0);
        check("R4 almost_empty_n after reset", 64'(b_almost_empty_n), 64'h0);
        check("R4 almost_full_n after reset", 64'(a_almost_full_n), 64'h1);
        check("R3 a_ready before load", 64'(a_ready), 64'h0);

        // R2: writes before loading are dropped
        @(negedge a_clk);
        a_cs_n = 1'b0; a_wr = 1'b1; a_en = 1'b1; a_data = 36'hDEAD_0001;
        wait_w(3);
        a_en = 1'b0; a_cs_n = 1'b1;
        load_cfg();
        wait_w(3);
        check("R3 a_ready after load", 64'(a_ready), 64'h1);
        wait_r(10);
        check("R2 no word from blocked write", 64'(b_ready), 64'h0);

        // R5: first-word fall-through latency
        @(negedge a_clk);
        a_cs_n = 1'b0; a_wr = 1'b1; a_mb = 1'b0; a_en = 1'b1; a_data = 36'h3_C0DE_0005;
        @(posedge a_clk);
        a_en <= 1'b0; a_cs_n <= 1'b1;
        exp_q.push_back(36'h3_C0DE_0005);
        n = 0;
        do begin
            @(posedge b_clk); n++;
            @(negedge b_clk);
        end while (!b_ready && n < 10);
        check_lat("R5 output-ready latency", n, 3, 4);
        check("R5 fall-through data", 64'(b_data), 64'h3_C0DE_0005);
        drain("R7");

        // R1: non-qualifying write decodes store nothing
        for (int k = 0; k < 4; k++) begin
            @(negedge a_clk);
            a_cs_n = (k == 0); a_wr = (k != 1); a_mb = (k == 2); a_en = (k != 3);
            a_data = 36'(k) | 36'hBAD0_0000;
            @(posedge a_clk);
            a_en <= 1'b0; a_cs_n <= 1'b1; a_mb <= 1'b0;
        end
        push_word(36'h1_1111_1111);
        wait_r(10);
        check("R1 only qualified word present", 64'(b_data), 64'h1_1111_1111);
        pop_word("R1");
        wait_r(10);
        check("R1 single word then empty", 64'(b_ready), 64'h0);

        // R6: non-qualifying read decodes hold the output word
        w1 = 36'h6_0000_00A1; w2 = 36'h6_0000_00B2;
        push_word(w1); push_word(w2);
        wait_r(10);
        for (int k = 0; k < 4; k++) begin
            @(negedge b_clk);
            b_cs_n = (k == 0); b_wr = (k != 1); b_mb = (k == 2); b_en = (k != 3);
            @(posedge b_clk);
            b_en <= 1'b0; b_cs_n <= 1'b1; b_mb <= 1'b0;
            @(negedge b_clk);
            check("R6 output held on bad decode", 64'(b_data), 64'(w1));
        end
        pop_word("R6");
        pop_word("R6");
        wait_r(10);
        check("R6 ready falls after last pop", 64'(b_ready), 64'h0);

        // R7: vector table of bursts
        for (int i = 0; i < NVEC; i++) begin
            for (int k = 0; k < int'(VECS[i].n_wr); k++) push_word(VECS[i].seed + 36'(k));
            for (int k = 0; k < int'(VECS[i].n_rd); k++) pop_word("R7 order/data");
            wait_r(8);
            check("R6 ready after burst", 64'(b_ready), 64'(VECS[i].exp_ready));
        end
        drain("R7");

        // R10: almost-empty boundary at offset AE_X
        for (int k = 0; k < AE_X; k++) push_word(36'h0_AE00_0000 + 36'(k));
        wait_r(10);
        check("R10 at offset low", 64'(b_almost_empty_n), 64'h0);
        push_word(36'h0_AE00_00FF);
        wait_r(10);
        check("R10 above offset high", 64'(b_almost_empty_n), 64'h1);
        pop_word("R10");
        wait_r(10);
        check("R10 back at offset low", 64'(b_almost_empty_n), 64'h0);
        drain("R7");
        check("R10 empty low", 64'(b_almost_empty_n), 64'h0);

        // R11: almost-full boundary at offset AF_Y (storage words only)
        for (int k = 0; k < DEPTH - AF_Y; k++) push_word(36'h0_AF00_0000 + 36'(k));
        wait_w(10);
        check("R11 free above offset high", 64'(a_almost_full_n), 64'h1);
        push_word(36'h0_AF0F_FFFF);
        wait_w(10);
        check("R11 free at offset low", 64'(a_almost_full_n), 64'h0);
        drain("R7");

        // R8: capacity, R2: blocked writes, R9: ready recovery
        accepted = 0; idle = 0;
        while (idle < 12) begin
            @(negedge a_clk);
            if (a_ready) begin
                a_cs_n = 1'b0; a_wr = 1'b1; a_mb = 1'b0; a_en = 1'b1;
                a_data = 36'(accepted) ^ 36'h9_0000_0000;
                @(posedge a_clk);
                a_en <= 1'b0; a_cs_n <= 1'b1;
                exp_q.push_back(36'(accepted) ^ 36'h9_0000_0000);
                accepted++; idle = 0;
            end else begin
                idle++;
            end
        end
        check("R8 capacity", 64'(accepted), 64'(DEPTH + 1));
        check("R8 ready low when full", 64'(a_ready), 64'h0);
        check("R11 almost-full when full", 64'(a_almost_full_n), 64'h0);
        @(negedge a_clk);
        a_cs_n = 1'b0; a_wr = 1'b1; a_en = 1'b1; a_data = 36'hB_ADBA_DBAD;
        wait_w(4);
        a_en = 1'b0; a_cs_n = 1'b1;
        @(negedge b_clk);
        check("R7 head word when full", 64'(b_data), 64'(exp_q.pop_front()));
        b_cs_n = 1'b0; b_wr = 1'b1; b_mb = 1'b0; b_en = 1'b1;
        @(posedge b_clk);
        b_en <= 1'b0; b_cs_n <= 1'b1;
        n = 0;
        do begin
            @(posedge a_clk); n++;
            @(negedge a_clk);
        end while (!a_ready && n < 10);
        check_lat("R9 input-ready recovery", n, 3, 4);
        drain("R7 after full");
        check("R2 no word from write while full", 64'(b_ready), 64'h0);

        // R12: reset discards contents
        push_word(36'h2_0000_0001); push_word(36'h2_0000_0002); push_word(36'h2_0000_0003);
        wait_r(10);
        check("R12 word present before reset", 64'(b_ready), 64'h1);
        rst_n = 1'b0;
        wait_w(3);
        exp_q.delete();
        rst_n = 1'b1;
        wait_w(5);
        check("R12 ready low after reset", 64'(b_ready), 64'h0);
        check("R12 almost_empty_n low after reset", 64'(b_almost_empty_n), 64'h0);
        check("R3 a_ready low after reset", 64'(a_ready), 64'h0);
        load_cfg();
        wait_w(3);
        check("R3 a_ready after reload", 64'(a_ready), 64'h1);
        wait_r(10);
        check("R12 no stale words", 64'(b_ready), 64'h0);

        summary();
    end

endmodule